// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog with two timed phases per service cycle. Once software turns it on, the block first runs a guard phase in which service is forbidden. It then runs a service phase in which service is required. Servicing the block in the service phase starts a fresh cycle from the guard phase. Servicing it too early raises the reset request. Letting the service phase run out also raises the reset request, and in that case the block sets an expiry flag as well.

Software reaches the block through a single-cycle register port. Writes take effect on the clock edge. Reads are combinational from the address. The control register is protected by a one-shot unlock register: software arms the unlock, and the next write to the control register either uses it or is ignored. The two phase lengths are plain cycle counts. Software programs them while the timer is stopped, and they cannot be changed while it runs.

Top module: `win_watchdog`

## Requirements
- R1: After reset, rst_req_o and irq_o are 0 and every register reads 0. Offset 0x08 and any unmapped offset always read 0.
- R2: Writing 1 to bit 0 at offset 0x00 arms the unlock, which reads back at bit 0 of 0x00. Any write to the control register at 0x04 clears the unlock. A control write made while the unlock is not armed has no effect.
- R3: The guard length at 0x0C and the service length at 0x10 read back as written. Writes to either are ignored while the timer runs.
- R4: An unlocked control write with bit 0 = 1 starts the timer. For guard length N and service length M, with no service, rst_req_o and irq_o rise N+M cycles after the starting write edge. irq_o reads back at bit 16 of 0x04.
- R5: An unlocked control write with bits 0 and 8 set, made while the timer runs and lands in the service phase, restarts the guard phase. This also holds on the final service cycle, where the service takes priority over expiry.
- R6: A service whose write edge falls in the guard phase sets rst_req_o on that edge and leaves irq_o at 0.
- R7: Once set, rst_req_o stays set until an unlocked control write with bit 0 = 0 or reset. That write also clears irq_o and stops the timer. Services made after the trip have no effect.
- R8: A guard length of 0 starts directly in the service phase. A service length of 0 expires as soon as the service phase is entered. If both are 0, the block trips at the starting edge.
- R9: Bit 0 of 0x04 reads 1 while the timer runs, including after a trip. Bit 8 of 0x04 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; rdata_o is 0 when low |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data |
| rst_req_o | output | 1 | Reset request, held until stopped |
| irq_o | output | 1 | Expiry flag (service phase ran out) |

## Verification
Register writes take effect on the edge that samples them. The bench drives each write from one falling edge and checks the result at the next falling edge, and it reads register values combinationally between edges. The reset request is due exactly N+M edges after the starting write when there is no service. An early service trips the block on its own edge. A service in the service phase moves the trip to N+M edges after the service edge. The bench steps one edge at a time from the starting write and compares both outputs at every falling edge against a bench function of N, M and the service offset. This covers the cycle just before each trip as well as the trip cycle itself.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GUARD  = 2'd1,
    PH_SERVE  = 2'd2,
    PH_TRIP   = 2'd3
  } phase_e;

  localparam int unsigned OFF_UNLOCK = 'h00;
  localparam int unsigned OFF_CTRL   = 'h04;
  localparam int unsigned OFF_SPARE  = 'h08;
  localparam int unsigned OFF_GUARD  = 'h0C;
  localparam int unsigned OFF_SERVE  = 'h10;

  localparam int unsigned BIT_RUN    = 0;
  localparam int unsigned BIT_KICK   = 8;
  localparam int unsigned BIT_EXPIRE = 16;
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              active_i,
  input  logic              expired_i,
  output logic              unlock_o,
  output logic [CNT_W-1:0]  guard_len_o,
  output logic [CNT_W-1:0]  serve_len_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              kick_o
);
  localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_GUARD  = ADDR_W'(OFF_GUARD);
  localparam logic [ADDR_W-1:0] A_SERVE  = ADDR_W'(OFF_SERVE);

  logic unlock_q;
  logic [CNT_W-1:0] guard_q, serve_q;
  logic ctrl_ok;

  assign ctrl_ok = wr_en_i && (addr_i == A_CTRL) && unlock_q;
  assign stop_o  = ctrl_ok && !wdata_i[BIT_RUN];
  assign start_o = ctrl_ok && wdata_i[BIT_RUN] && !active_i;
  assign kick_o  = ctrl_ok && wdata_i[BIT_RUN] && wdata_i[BIT_KICK] && active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
    end else if (wr_en_i && addr_i == A_UNLOCK) begin
      unlock_q <= wdata_i[0];
    end else if (wr_en_i && addr_i == A_CTRL) begin
      unlock_q <= 1'b0;  // one-shot: any control write uses it up
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q <= '0;
      serve_q <= '0;
    end else if (wr_en_i && !active_i) begin
      if (addr_i == A_GUARD) guard_q <= wdata_i[CNT_W-1:0];
      if (addr_i == A_SERVE) serve_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_UNLOCK: rdata_o[0] = unlock_q;
        A_CTRL: begin
          rdata_o[BIT_RUN]    = active_i;
          rdata_o[BIT_EXPIRE] = expired_i;
        end
        A_GUARD: rdata_o = DATA_W'(guard_q);
        A_SERVE: rdata_o = DATA_W'(serve_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign unlock_o    = unlock_q;
  assign guard_len_o = guard_q;
  assign serve_len_o = serve_q;
endmodule

// File: rtl/wwdt_engine.sv
module wwdt_engine
  import wwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] guard_len_i,
  input  logic [CNT_W-1:0] serve_len_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             kick_i,
  output phase_e           phase_o,
  output logic             active_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    exp_d   = exp_q;
    if (stop_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      exp_d   = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          if (guard_len_i != '0) begin
            phase_d = PH_GUARD; cnt_d = guard_len_i;
          end else if (serve_len_i != '0) begin
            phase_d = PH_SERVE; cnt_d = serve_len_i;
          end else begin
            phase_d = PH_TRIP;  exp_d = 1'b1;
          end
        end
        PH_GUARD: begin
          if (kick_i) begin
            phase_d = PH_TRIP;  // early service
          end else if (cnt_q <= ONE) begin
            if (serve_len_i != '0) begin
              phase_d = PH_SERVE; cnt_d = serve_len_i;
            end else begin
              phase_d = PH_TRIP;  exp_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        PH_SERVE: begin
          if (kick_i) begin
            if (guard_len_i != '0) begin
              phase_d = PH_GUARD; cnt_d = guard_len_i;
            end else begin
              phase_d = PH_SERVE; cnt_d = serve_len_i;
            end
          end else if (cnt_q <= ONE) begin
            phase_d = PH_TRIP; exp_d = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: ;  // tripped: hold until stopped
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      exp_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      exp_q   <= exp_d;
    end
  end

  assign phase_o   = phase_q;
  assign active_o  = (phase_q != PH_IDLE);
  assign expired_o = exp_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic             unlock, active, expired, start, stop, kick;
  logic [CNT_W-1:0] guard_len, serve_len;
  phase_e           phase;

  wwdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .active_i(active), .expired_i(expired), .unlock_o(unlock),
    .guard_len_o(guard_len), .serve_len_o(serve_len),
    .start_o(start), .stop_o(stop), .kick_o(kick)
  );

  wwdt_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni, .guard_len_i(guard_len), .serve_len_i(serve_len),
    .start_i(start), .stop_i(stop), .kick_i(kick),
    .phase_o(phase), .active_o(active), .expired_o(expired)
  );

  assign rst_req_o = (phase == PH_TRIP);
  assign irq_o     = expired;
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker
  import wwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic              unlock,
  input logic              active,
  input logic              kick,
  input logic [CNT_W-1:0]  guard_len,
  input logic [CNT_W-1:0]  serve_len,
  input phase_e            phase
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));

  assert_trip_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !ctrl_wr) |=> rst_req_o);

  assert_flag_needs_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rst_req_o);

  assert_unlock_used_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !unlock);

  assert_locked_ctrl_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !unlock && phase == PH_IDLE) |=> phase == PH_IDLE);

  assert_guard_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && active && addr_i == ADDR_W'(OFF_GUARD)) |=> $stable(guard_len));

  assert_serve_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && active && addr_i == ADDR_W'(OFF_SERVE)) |=> $stable(serve_len));

  assert_early_kick_trips_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_GUARD && kick) |=> (rst_req_o && !irq_o));

  assert_kick_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(OFF_CTRL)) |-> !rdata_o[BIT_KICK]);
endmodule

bind win_watchdog wwdt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o), .irq_o(irq_o),
  .unlock(unlock), .active(active), .kick(kick),
  .guard_len(guard_len), .serve_len(serve_len), .phase(phase)
);

// File: tb/tb_win_watchdog.sv
`timescale 1ns/1ps
module tb_win_watchdog;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic              rd_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              rst_req_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  win_watchdog dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    #0.5;
    d = rdata_o;
    rd_en_i = 1'b0; addr_i = '0;
  endtask

  task automatic ctrl(logic [31:0] d);
    wr(5'h00, 32'h1);
    wr(5'h04, d);
  endtask

  // edge offset (from starting edge) at which reset request rises
  function automatic int exp_trip(int n, int m, int e);
    if (e < 2 || e > n + m) return n + m;
    if (e <= n) return e;
    return e + n + m;
  endfunction

  function automatic bit exp_flag(int n, int m, int e);
    if (e < 2 || e > n + m) return 1'b1;
    return (e > n);
  endfunction

  task automatic run_case(string tag, int n, int m, int e);
    int trip;
    bit flag;
    logic [31:0] d;
    trip = exp_trip(n, m, e);
    flag = exp_flag(n, m, e);
    ctrl(32'h0);
    wr(5'h0C, n);
    wr(5'h10, m);
    ctrl(32'h1);  // starting edge k
    chk({tag, " rst t0"}, rst_req_o, (trip == 0));
    chk({tag, " irq t0"}, irq_o, (trip == 0) && flag);
    for (int t = 1; t <= trip + 3; t++) begin
      if (e >= 2 && t == e - 1) begin
        wr_en_i = 1'b1; addr_i = 5'h00; wdata_i = 32'h1;
      end else if (e >= 2 && t == e) begin
        wr_en_i = 1'b1; addr_i = 5'h04; wdata_i = 32'h101;
      end
      @(negedge clk_i);
      wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
      chk({tag, " rst"}, rst_req_o, (t >= trip));
      chk({tag, " irq"}, irq_o, (t >= trip) && flag);
    end
    rd(5'h04, d);
    chk({tag, " R9 status"}, d, {15'b0, flag, 15'b0, 1'b1});
    ctrl(32'h0);
    chk({tag, " R7 cleared rst"}, rst_req_o, 0);
    chk({tag, " R7 cleared irq"}, irq_o, 0);
    rd(5'h04, d);
    chk({tag, " R7 stopped"}, d, 0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 irq", irq_o, 0);
    for (int a = 0; a <= 'h14; a += 4) begin
      rd(ADDR_W'(a), d);
      chk("R1 read", d, 0);
    end

    // R2 locked control write ignored
    wr(5'h04, 32'h1);
    rd(5'h04, d);
    chk("R2 locked write", d, 0);
    wr(5'h00, 32'h1);
    rd(5'h00, d);
    chk("R2 unlock armed", d, 1);
    wr(5'h04, 32'h0);
    rd(5'h00, d);
    chk("R2 unlock consumed", d, 0);
    wr(5'h04, 32'h1);
    rd(5'h04, d);
    chk("R2 second write ignored", d, 0);

    // R3 count registers
    wr(5'h0C, 32'd50);
    wr(5'h10, 32'd70);
    rd(5'h0C, d); chk("R3 guard readback", d, 50);
    rd(5'h10, d); chk("R3 serve readback", d, 70);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); chk("R1 spare reads 0", d, 0);
    ctrl(32'h1);
    rd(5'h04, d); chk("R9 running", d, 1);
    wr(5'h0C, 32'd9);
    wr(5'h10, 32'd9);
    rd(5'h0C, d); chk("R3 guard frozen", d, 50);
    rd(5'h10, d); chk("R3 serve frozen", d, 70);
    ctrl(32'h0);

    // directed corners
    run_case("R4 expiry", 4, 6, 0);
    run_case("R5 open kick", 4, 6, 7);
    run_case("R5 last cycle kick", 4, 6, 10);
    run_case("R6 early kick", 4, 6, 3);
    run_case("R6 last guard kick", 4, 6, 4);
    run_case("R8 no guard", 0, 5, 3);
    run_case("R8 no serve", 3, 0, 0);
    run_case("R8 both zero", 0, 0, 0);
    run_case("R7 kick after trip", 2, 3, 8);

    // randomized cases
    for (int i = 0; i < 40; i++) begin
      int n, m, e;
      n = $urandom_range(0, 9);
      m = $urandom_range(0, 9);
      e = $urandom_range(0, n + m + 2);
      run_case("R4 R5 R6 random", n, m, e);
    end

    summary();
  end
endmodule